// File: doc/BRIEF.md
# Power Mode Transition Controller

This block sequences the supply regulator of a low-power microcontroller through three operating modes: normal, economy and a charge-pump super economy mode. Software selects a policy through a small register bus. The policy is automatic, forced economy or super economy. The mode field is guarded by a 16-bit unlock key, so a stray write cannot change the regulator mode.

In automatic mode the controller reacts to CPU sleep and wake events. The reaction depends on which clock sources keep running. Settling delays are counted in millisecond ticks. Leaving super economy mode always passes through economy first. A sticky completion flag, which can raise a level interrupt, reports when a timed transition has finished. The analog regulator, the charge pump, the oscillators and supply-voltage detection are outside this block. They appear only as status inputs.

Register map: address 0 is the key register, address 1 is the mode select (bits 2:0), address 2 holds the flags (write 1 to clear; bit 0 is done, bit 1 is error), and address 3 holds the interrupt enable (bit 0). Clock source 0 is the low-speed oscillator.

Top module: `pwr_mode_seq`

## Requirements
- R1: Writing 0x0096 to address 0 removes protection, and writing any other value there restores it. While protected, writes to address 1 are discarded: `mode_sel`, `reg_mode` and `err_flag` keep their values.
- R2: `reg_mode` encodes 0 for normal, 1 for economy and 2 for super economy. The select codes at address 1 are 0 for automatic, 3 for economy and 5 for super economy. Any other code is ignored. After reset, `mode_sel` is 0 and `reg_mode` is 0, and both flags and `irq` are 0.
- R3: A request for code 5 is accepted only when `lso_stable` is 1 and `clk_run[NCLK-1:1]` are all 0. When accepted, `mode_sel` becomes 5 and `reg_mode` becomes 2 on the next cycle. Otherwise `mode_sel` is unchanged and the sticky `err_flag` is set. Writing 1 to address 2 bit 1 clears `err_flag`.
- R4: Writing code 0 or 3 while in super economy mode starts a settle of SETTLE_MS ticks. `done_flag` is set on the edge that samples the SETTLE_MS-th tick. At that point `reg_mode` becomes economy for code 3 or while asleep. Otherwise it takes the automatic awake target of R7.
- R5: In automatic mode, a sleep event with `clk_keep` all 0 makes `reg_mode` economy on the next cycle and leaves `done_flag` unchanged.
- R6: In automatic mode, a sleep event with `clk_keep` equal to only bit 0 leaves `reg_mode` unchanged until the SLEEP_MS-th tick. On that tick `reg_mode` becomes economy and `done_flag` is set. Any other `clk_keep` value changes nothing.
- R7: In automatic mode, a wake event sets `reg_mode` on the next cycle: economy if `clk_run` has only bit 0 set, normal otherwise. A pending sleep wait is cancelled.
- R8: `reg_mode` never goes from super economy straight to normal. The cycle after the leave request shows economy.
- R9: `done_flag` is sticky and is cleared only by writing 1 to address 2 bit 0. `irq` equals `done_flag` while the enable at address 3 bit 0 is 1.
- R10: An accepted write of code 0 or 3 during a running settle restarts the count from zero.
- R11: Outside super economy mode and its settle, code 3 gives economy on the next cycle. Code 0 gives the R7 target while awake, or economy while asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| bus_we | input | 1 | register write strobe |
| bus_addr | input | 2 | register address |
| bus_wdata | input | 16 | write data |
| ms_tick | input | 1 | one-cycle millisecond tick |
| cpu_sleep | input | 1 | CPU sleep entry pulse |
| cpu_wake | input | 1 | CPU wake pulse |
| clk_run | input | NCLK | clock sources running, bit 0 low-speed |
| clk_keep | input | NCLK | clock sources kept during sleep |
| lso_stable | input | 1 | low-speed oscillator stable |
| reg_mode | output | 2 | active regulator mode |
| mode_sel | output | 3 | current mode select readback |
| done_flag | output | 1 | transition-complete flag |
| err_flag | output | 1 | rejected super economy request |
| irq | output | 1 | level interrupt |

## Verification
Register writes, sleep events and wake events take effect on the clock edge that samples the strobe. Their results are therefore checked one cycle later, at the following falling edge. Timed results appear on the edge that samples the final millisecond tick. The bench counts ticks and checks one tick early (no change) and exactly on time. All stimulus is applied at falling edges, and every sample is taken at the next falling edge. This keeps each check aligned to the register that produces it.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [1:0] {
    RM_NORMAL = 2'd0,
    RM_ECO    = 2'd1,
    RM_SECO   = 2'd2
  } regmode_t;

  typedef enum logic [1:0] {
    SLP_NONE = 2'd0,
    SLP_NOW  = 2'd1,
    SLP_WAIT = 2'd2
  } sleepact_t;

  localparam int SELW = 3;
  localparam logic [SELW-1:0] SEL_AUTO = 3'd0;
  localparam logic [SELW-1:0] SEL_ECO  = 3'd3;
  localparam logic [SELW-1:0] SEL_SECO = 3'd5;

  localparam logic [15:0] UNLOCK_KEY = 16'h0096;

  localparam logic [1:0] ADDR_KEY  = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;
  localparam logic [1:0] ADDR_IEN  = 2'd3;

  function automatic logic f_sel_valid(input logic [SELW-1:0] s);
    return (s == SEL_AUTO) || (s == SEL_ECO) || (s == SEL_SECO);
  endfunction
endpackage

// File: rtl/pms_busif.sv
module pms_busif
  import pms_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic            mode_wr,
  output logic [SELW-1:0] mode_wdata,
  output logic            clr_done,
  output logic            clr_err,
  output logic            irq_en,
  output logic            unlocked
);
  logic hit_key, hit_mode, hit_flag, hit_ien;

  assign hit_key  = we && (addr == ADDR_KEY);
  assign hit_mode = we && (addr == ADDR_MODE);
  assign hit_flag = we && (addr == ADDR_FLAG);
  assign hit_ien  = we && (addr == ADDR_IEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      irq_en   <= 1'b0;
    end else begin
      if (hit_key) unlocked <= (wdata[15:0] == UNLOCK_KEY);
      if (hit_ien) irq_en <= wdata[0];
    end
  end

  assign mode_wr    = hit_mode && unlocked;
  assign mode_wdata = wdata[SELW-1:0];
  assign clr_done   = hit_flag && wdata[0];
  assign clr_err    = hit_flag && wdata[1];

  // R1: any key other than the unlock value restores protection
  assert_wrong_key_locks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_key && wdata[15:0] != UNLOCK_KEY) |=> !unlocked);
endmodule

// File: rtl/pms_timer.sv
module pms_timer #(
  parameter int LONG_N  = 10,
  parameter int SHORT_N = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic start_long,
  input  logic cancel,
  output logic busy,
  output logic is_long,
  output logic expire
);
  localparam int MAXN = (LONG_N > SHORT_N) ? LONG_N : SHORT_N;
  localparam int CW   = $clog2(MAXN + 1);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] f_last(input logic lng);
    return lng ? CW'(LONG_N - 1) : CW'(SHORT_N - 1);
  endfunction

  assign expire = busy && tick && (cnt == f_last(is_long));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      is_long <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      is_long <= start_long;
      cnt     <= '0;
    end else if (cancel || expire) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy && tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: an expiry closes the window unless a new one opens in that cycle
  assert_expire_ends_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !start) |=> !busy);
  // R10: a restart puts the count back to zero
  assert_restart_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && cnt == '0));
endmodule

// File: rtl/pms_core.sv
module pms_core
  import pms_pkg::*;
#(
  parameter int NCLK = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_wr,
  input  logic [SELW-1:0] mode_wdata,
  input  logic            clr_done,
  input  logic            clr_err,
  input  logic            cpu_sleep,
  input  logic            cpu_wake,
  input  logic [NCLK-1:0] clk_run,
  input  logic [NCLK-1:0] clk_keep,
  input  logic            lso_stable,
  input  logic            t_busy,
  input  logic            t_is_long,
  input  logic            t_expire,
  output logic            t_start,
  output logic            t_start_long,
  output logic            t_cancel,
  output regmode_t        reg_mode,
  output logic [SELW-1:0] mode_sel,
  output logic            done,
  output logic            err
);
  function automatic logic f_only_lso(input logic [NCLK-1:0] v);
    return v == NCLK'(1);
  endfunction

  function automatic logic f_seco_ok(input logic [NCLK-1:0] run, input logic stable);
    return stable && (run[NCLK-1:1] == '0);
  endfunction

  function automatic regmode_t f_wake_target(input logic [NCLK-1:0] run);
    return f_only_lso(run) ? RM_ECO : RM_NORMAL;
  endfunction

  function automatic sleepact_t f_sleep_act(input logic [NCLK-1:0] keep);
    if (keep == '0)       return SLP_NOW;
    if (f_only_lso(keep)) return SLP_WAIT;
    return SLP_NONE;
  endfunction

  logic            asleep;
  logic            n_asleep, set_done, set_err;
  logic [SELW-1:0] n_sel;
  regmode_t        n_rm;
  logic            seco_ok, in_settle, ev_wake, ev_sleep;

  assign seco_ok   = f_seco_ok(clk_run, lso_stable);
  assign in_settle = t_busy && t_is_long;
  assign ev_wake   = cpu_wake && asleep;
  assign ev_sleep  = cpu_sleep && !asleep;

  always_comb begin
    n_sel        = mode_sel;
    n_rm         = reg_mode;
    n_asleep     = asleep;
    set_done     = 1'b0;
    set_err      = 1'b0;
    t_start      = 1'b0;
    t_start_long = 1'b0;
    t_cancel     = 1'b0;
    if (mode_wr && f_sel_valid(mode_wdata)) begin
      if (mode_wdata == SEL_SECO) begin
        if (!seco_ok) begin
          set_err = 1'b1;
        end else if (mode_sel != SEL_SECO) begin
          n_sel    = SEL_SECO;
          n_rm     = RM_SECO;
          t_cancel = t_busy;
        end
      end else if (mode_sel == SEL_SECO || in_settle) begin
        n_sel        = mode_wdata;
        n_rm         = RM_ECO;
        t_start      = 1'b1;
        t_start_long = 1'b1;
      end else begin
        n_sel = mode_wdata;
        if (mode_wdata == SEL_ECO) begin
          n_rm     = RM_ECO;
          t_cancel = t_busy;
        end else if (t_busy) begin
          t_start = 1'b1;
        end else begin
          n_rm = asleep ? RM_ECO : f_wake_target(clk_run);
        end
      end
    end else if (ev_wake) begin
      n_asleep = 1'b0;
      if (t_busy && !t_is_long) t_cancel = 1'b1;
      if (mode_sel == SEL_AUTO && !in_settle) n_rm = f_wake_target(clk_run);
    end else if (ev_sleep) begin
      n_asleep = 1'b1;
      if (mode_sel == SEL_AUTO && !t_busy) begin
        unique case (f_sleep_act(clk_keep))
          SLP_NOW:  n_rm = RM_ECO;
          SLP_WAIT: t_start = 1'b1;
          default:  ;
        endcase
      end
    end else if (t_expire) begin
      set_done = 1'b1;
      if (t_is_long && mode_sel == SEL_AUTO && !asleep) n_rm = f_wake_target(clk_run);
      else n_rm = RM_ECO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_sel <= SEL_AUTO;
      reg_mode <= RM_NORMAL;
      asleep   <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      mode_sel <= n_sel;
      reg_mode <= n_rm;
      asleep   <= n_asleep;
      if (set_done)      done <= 1'b1;
      else if (clr_done) done <= 1'b0;
      if (set_err)       err <= 1'b1;
      else if (clr_err)  err <= 1'b0;
    end
  end

  // R3: super economy is only ever entered under valid clock conditions
  assert_seco_entry_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_mode == RM_SECO && $past(reg_mode) != RM_SECO) |-> $past(seco_ok));
  // R8: no direct step from super economy to normal
  assert_no_seco_to_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_mode) == RM_SECO) |-> (reg_mode != RM_NORMAL));
  // R9: the completion flag holds until cleared
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr_done) |=> done);
  // R5: sleep with nothing kept goes to economy without a flag
  assert_sleep_now_no_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sleep && !mode_wr && mode_sel == SEL_AUTO && !t_busy && clk_keep == '0 && !done)
      |=> (reg_mode == RM_ECO && !done));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int NCLK      = 4,
  parameter int SETTLE_MS = 10,
  parameter int SLEEP_MS  = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [1:0]      bus_addr,
  input  logic [15:0]     bus_wdata,
  input  logic            ms_tick,
  input  logic            cpu_sleep,
  input  logic            cpu_wake,
  input  logic [NCLK-1:0] clk_run,
  input  logic [NCLK-1:0] clk_keep,
  input  logic            lso_stable,
  output logic [1:0]      reg_mode,
  output logic [2:0]      mode_sel,
  output logic            done_flag,
  output logic            err_flag,
  output logic            irq
);
  logic            mode_wr, clr_done, clr_err, irq_en, unlocked;
  logic [SELW-1:0] mode_wdata;
  logic            t_busy, t_is_long, t_expire, t_start, t_start_long, t_cancel;
  regmode_t        rm;

  pms_busif #(.DW(16)) u_bus (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .clr_done(clr_done),
    .clr_err(clr_err), .irq_en(irq_en), .unlocked(unlocked)
  );

  pms_timer #(.LONG_N(SETTLE_MS), .SHORT_N(SLEEP_MS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .start(t_start),
    .start_long(t_start_long), .cancel(t_cancel), .busy(t_busy),
    .is_long(t_is_long), .expire(t_expire)
  );

  pms_core #(.NCLK(NCLK)) u_core (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .clr_done(clr_done), .clr_err(clr_err), .cpu_sleep(cpu_sleep),
    .cpu_wake(cpu_wake), .clk_run(clk_run), .clk_keep(clk_keep),
    .lso_stable(lso_stable), .t_busy(t_busy), .t_is_long(t_is_long),
    .t_expire(t_expire), .t_start(t_start), .t_start_long(t_start_long),
    .t_cancel(t_cancel), .reg_mode(rm), .mode_sel(mode_sel),
    .done(done_flag), .err(err_flag)
  );

  assign reg_mode = rm;
  assign irq      = done_flag && irq_en;

  // R1: protected mode writes leave the selection and error untouched
  assert_locked_write_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_MODE && !unlocked) |=> ($stable(mode_sel) && $stable(err_flag)));
endmodule

// File: tb/tb_pwr_mode_seq.sv
`timescale 1ns/1ps
module tb_pwr_mode_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        ms_tick = 1'b0, cpu_sleep = 1'b0, cpu_wake = 1'b0;
  logic [3:0]  clk_run = 4'b0011, clk_keep = 4'b0000;
  logic        lso_stable = 1'b1;
  logic [1:0]  reg_mode;
  logic [2:0]  mode_sel;
  logic        done_flag, err_flag, irq;

  int nchk = 0, nfail = 0;
  int exp_rm = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwr_mode_seq dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ms_tick(ms_tick), .cpu_sleep(cpu_sleep),
    .cpu_wake(cpu_wake), .clk_run(clk_run), .clk_keep(clk_keep),
    .lso_stable(lso_stable), .reg_mode(reg_mode), .mode_sel(mode_sel),
    .done_flag(done_flag), .err_flag(err_flag), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic tick();
    ms_tick = 1'b1; @(negedge clk); ms_tick = 1'b0;
  endtask

  task automatic go_sleep();
    cpu_sleep = 1'b1; @(negedge clk); cpu_sleep = 1'b0;
  endtask

  task automatic go_wake();
    cpu_wake = 1'b1; @(negedge clk); cpu_wake = 1'b0;
  endtask

  function automatic int wake_tgt(input logic [3:0] r);
    return (r == 4'b0001) ? 1 : 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset reg_mode", reg_mode, 0);
    chk("R2 reset mode_sel", mode_sel, 0);
    chk("R2 reset done", done_flag, 0);
    chk("R2 reset err", err_flag, 0);
    chk("R9 reset irq", irq, 0);

    // R1: protected writes discarded
    wr(1, 16'd3);
    chk("R1 locked sel", mode_sel, 0);
    chk("R1 locked rm", reg_mode, 0);
    wr(1, 16'd5);
    chk("R1 locked no err", err_flag, 0);

    // R2/R11: sweep every select code while unlocked
    wr(0, 16'h0096);
    for (int c = 0; c < 8; c++) begin
      wr(1, 16'(c));
      if (c == 3) begin
        chk("R11 eco sel", mode_sel, 3);
        chk("R11 eco rm", reg_mode, 1);
      end else if (c == 5) begin
        chk("R3 reject sel", mode_sel, 0);
        chk("R3 reject err", err_flag, 1);
        wr(2, 16'h0002);
        chk("R3 err clear", err_flag, 0);
      end else begin
        chk("R2 code ignored sel", mode_sel, 0);
        chk("R2 code ignored rm", reg_mode, 0);
      end
      wr(1, 16'd0);
      chk("R11 auto awake target", reg_mode, 0);
    end

    // R1: relock with a wrong key
    wr(0, 16'h1234);
    wr(1, 16'd3);
    chk("R1 relocked sel", mode_sel, 0);
    chk("R1 relocked rm", reg_mode, 0);
    wr(0, 16'h0096);

    // R3/R4/R8: precondition sweep for super economy
    exp_rm = 0;
    for (int r = 0; r < 16; r++) begin
      for (int s = 0; s < 2; s++) begin
        logic ok;
        clk_run = 4'(r); lso_stable = s[0];
        ok = (r[3:1] == 3'b000) && (s == 1);
        wr(1, 16'd5);
        if (ok) begin
          chk("R3 accept rm", reg_mode, 2);
          chk("R3 accept sel", mode_sel, 5);
          chk("R3 accept no err", err_flag, 0);
          wr(1, 16'd0);
          chk("R8 leave via eco", reg_mode, 1);
          repeat (9) tick();
          chk("R4 not yet done", done_flag, 0);
          chk("R4 still eco", reg_mode, 1);
          tick();
          chk("R4 done on tick", done_flag, 1);
          exp_rm = wake_tgt(4'(r));
          chk("R4 settle target", reg_mode, exp_rm);
          wr(2, 16'h0001);
          chk("R9 done clear", done_flag, 0);
        end else begin
          chk("R3 reject sel", mode_sel, 0);
          chk("R3 reject rm", reg_mode, exp_rm);
          chk("R3 reject err", err_flag, 1);
          wr(2, 16'h0002);
        end
      end
    end

    // R10: restart of the settle count
    clk_run = 4'b0001; lso_stable = 1'b1;
    wr(1, 16'd5);
    wr(1, 16'd0);
    repeat (5) tick();
    wr(1, 16'd3);
    chk("R10 restart eco", reg_mode, 1);
    repeat (9) tick();
    chk("R10 restarted not done", done_flag, 0);
    tick();
    chk("R10 done after full count", done_flag, 1);
    chk("R4 eco select target", reg_mode, 1);
    wr(2, 16'h0001);
    wr(1, 16'd0);
    chk("R11 auto lso only", reg_mode, 1);
    clk_run = 4'b0011;
    wr(1, 16'd0);
    chk("R11 auto with fast clock", reg_mode, 0);

    // R5/R6/R7: sweep sleep keep masks in automatic mode
    for (int k = 0; k < 16; k++) begin
      clk_keep = 4'(k);
      go_sleep();
      if (k == 0) begin
        chk("R5 sleep now eco", reg_mode, 1);
        chk("R5 no flag", done_flag, 0);
      end else if (k == 1) begin
        chk("R6 wait holds", reg_mode, 0);
        tick();
        chk("R6 eco after wait", reg_mode, 1);
        chk("R6 flag set", done_flag, 1);
        wr(2, 16'h0001);
      end else begin
        tick();
        chk("R6 other mask no change", reg_mode, 0);
        chk("R6 other mask no flag", done_flag, 0);
      end
      go_wake();
      chk("R7 wake normal", reg_mode, 0);
    end

    // R7: wake cancels a pending wait and picks economy on slow clock only
    clk_keep = 4'b0001;
    go_sleep();
    clk_run = 4'b0001;
    go_wake();
    chk("R7 wake eco", reg_mode, 1);
    tick();
    chk("R7 wait cancelled", done_flag, 0);

    // R9: interrupt enable and write-1-clear
    go_sleep();
    tick();
    chk("R9 flag set", done_flag, 1);
    chk("R9 irq masked", irq, 0);
    wr(2, 16'h0000);
    chk("R9 write 0 keeps flag", done_flag, 1);
    wr(3, 16'h0001);
    chk("R9 irq enabled", irq, 1);
    wr(2, 16'h0001);
    chk("R9 cleared flag", done_flag, 0);
    chk("R9 irq dropped", irq, 0);
    go_wake();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule